// File: doc/BRIEF.md
# Programmable Baud Rate Generator

This block turns a fast system clock, qualified by an input clock enable, into a slower square wave used as a serial shift clock. Every enabled input cycle first passes through a prescale stage. That stage divides by two in the fast mode, or by thirty-two in the slow mode (a halving stage followed by a divide-by-16). Each prescaler output pulse decrements an 8-bit down counter. When the counter reaches its terminal count, it reloads from an 8-bit time constant register and flips an output flip-flop. This gives an output period of 4 x TC enabled input cycles in the fast mode and 64 x TC in the slow mode.

Two write ports load the block: one for the time constant and one for a two-bit control word. The control word holds the enable bit and the mode bit. A single-cycle tick accompanies every output edge, so logic downstream can act on the edge without its own edge detector. When the block is disabled, its output stays low. When it is enabled again, it starts a fresh count.

Top module: `baud_rate_gen`

## Requirements
- R1: After reset `baud_out` and `baud_tick` are 0 and the generator is disabled.
- R2: In fast mode (control bit 1 = 0), with `clk_en` held high, `baud_out` toggles every 2 x TC clock cycles, so the output period is 4 x TC input cycles. TC = 1 gives one quarter of the input rate.
- R3: In slow mode (control bit 1 = 1), `baud_out` toggles every 32 x TC enabled input cycles, so the output period is 64 x TC.
- R4: A time constant of 0 divides as 256.
- R5: A time constant written while the generator runs does not shorten or lengthen the half-period in progress. It applies from the next reload.
- R6: While control bit 0 (enable) is 0, `baud_out` is 0 and `baud_tick` stays low. After an enabling control write, the first toggle comes 2 x TC + 1 cycles later in fast mode with `clk_en` high, because the count restarts from a cleared prescaler and a full time constant.
- R7: `baud_tick` is high for exactly one cycle, in the cycle when `baud_out` has just changed because of a terminal count. Every rise of `baud_out` comes with a tick.
- R8: Cycles with `clk_en` low do not advance the generator. With `clk_en` high every other cycle, the half-period in clock cycles doubles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clk_en | input | 1 | Input clock enable; one high cycle is one input clock |
| tc_we | input | 1 | Write strobe for the time constant register |
| tc_wdata | input | 8 | Time constant value (0 means 256) |
| ctl_we | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 2 | Bit 0 enable, bit 1 mode (1 = divide by 64) |
| baud_out | output | 1 | Square-wave baud clock |
| baud_tick | output | 1 | One-cycle pulse marking each edge of `baud_out` |

## Verification
A wrong prescaler or counter state shows up at the ports as a shifted output edge. A wrong prescaler appears within one half-period of the output. A wrong reload value appears at the latest one half-period after the next reload. A lost enable or mode bit changes the very next tick interval. The bench therefore compares `baud_out` and `baud_tick` with a behavioural model on every clock, and it times whole tick intervals against the products of prescale and constant.

// File: rtl/baud_pkg.sv
package baud_pkg;
  typedef enum logic {
    DIV_FAST = 1'b0,
    DIV_SLOW = 1'b1
  } div_mode_e;

  localparam int CTL_W       = 2;
  localparam int CTL_EN_BIT  = 0;
  localparam int CTL_MODE_BIT = 1;
endpackage

// File: rtl/baud_cfg_regs.sv
module baud_cfg_regs
  import baud_pkg::*;
#(
  parameter int TC_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            tc_we,
  input  logic [TC_W-1:0] tc_wdata,
  input  logic            ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic [TC_W-1:0] tc_q,
  output logic            en_q,
  output div_mode_e       mode_q
);
  logic [TC_W-1:0] tc_d;
  logic            en_d;
  div_mode_e       mode_d;

  always_comb begin
    tc_d   = tc_q;
    en_d   = en_q;
    mode_d = mode_q;
    if (tc_we) begin
      tc_d = tc_wdata;
    end
    if (ctl_we) begin
      en_d   = ctl_wdata[CTL_EN_BIT];
      mode_d = div_mode_e'(ctl_wdata[CTL_MODE_BIT]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tc_q   <= '0;
      en_q   <= 1'b0;
      mode_q <= DIV_FAST;
    end else begin
      tc_q   <= tc_d;
      en_q   <= en_d;
      mode_q <= mode_d;
    end
  end
endmodule

// File: rtl/baud_prescale.sv
module baud_prescale
  import baud_pkg::*;
#(
  parameter int PRE_FAST = 2,
  parameter int PRE_SLOW = 32
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      run,
  input  logic      clk_en,
  input  div_mode_e mode,
  output logic      step
);
  localparam int PW = (PRE_SLOW > 2) ? $clog2(PRE_SLOW) : 1;
  localparam logic [PW-1:0] FAST_LAST = PW'(PRE_FAST - 1);
  localparam logic [PW-1:0] SLOW_LAST = PW'(PRE_SLOW - 1);

  logic [PW-1:0] pre_q, pre_d;
  logic [PW-1:0] last;
  logic          at_last;

  generate
    if (PRE_FAST == PRE_SLOW) begin : g_single
      assign last = FAST_LAST;
    end else begin : g_dual
      assign last = (mode == DIV_SLOW) ? SLOW_LAST : FAST_LAST;
    end
  endgenerate

  assign at_last = (pre_q >= last);
  assign step    = run && clk_en && at_last;

  always_comb begin
    pre_d = pre_q;
    if (!run) begin
      pre_d = '0;
    end else if (clk_en) begin
      if (at_last) begin
        pre_d = '0;
      end else begin
        pre_d = pre_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
    end else begin
      pre_q <= pre_d;
    end
  end
endmodule

// File: rtl/baud_countdown.sv
module baud_countdown #(
  parameter int TC_W = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            step,
  input  logic [TC_W-1:0] tc,
  output logic            term
);
  localparam logic [TC_W-1:0] ONE = TC_W'(1);

  logic [TC_W-1:0] cnt_q, cnt_d;

  assign term = run && step && (cnt_q == ONE);

  always_comb begin
    cnt_d = cnt_q;
    if (!run) begin
      cnt_d = tc;
    end else if (step) begin
      if (cnt_q == ONE) begin
        cnt_d = tc;
      end else begin
        cnt_d = cnt_q - ONE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/baud_toggle.sv
module baud_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic term,
  output logic out_q,
  output logic tick_q
);
  logic out_d, tick_d;

  always_comb begin
    out_d  = out_q;
    tick_d = 1'b0;
    if (!run) begin
      out_d = 1'b0;
    end else if (term) begin
      out_d  = ~out_q;
      tick_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q  <= 1'b0;
      tick_q <= 1'b0;
    end else begin
      out_q  <= out_d;
      tick_q <= tick_d;
    end
  end
endmodule

// File: rtl/baud_rate_gen.sv
module baud_rate_gen
  import baud_pkg::*;
#(
  parameter int TC_W     = 8,
  parameter int PRE_FAST = 2,
  parameter int PRE_SLOW = 32,
  parameter int SYNC_LEN = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clk_en,
  input  logic             tc_we,
  input  logic [TC_W-1:0]  tc_wdata,
  input  logic             ctl_we,
  input  logic [CTL_W-1:0] ctl_wdata,
  output logic             baud_out,
  output logic             baud_tick
);
  logic [SYNC_LEN-1:0] rst_pipe_q;
  logic                rst_sync_n;
  logic [TC_W-1:0]     tc_q;
  logic                en_q;
  div_mode_e           mode_q;
  logic                step;
  logic                term;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= {rst_pipe_q[SYNC_LEN-2:0], 1'b1};
    end
  end
  assign rst_sync_n = rst_pipe_q[SYNC_LEN-1];

  baud_cfg_regs #(.TC_W(TC_W)) u_cfg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .tc_we    (tc_we),
    .tc_wdata (tc_wdata),
    .ctl_we   (ctl_we),
    .ctl_wdata(ctl_wdata),
    .tc_q     (tc_q),
    .en_q     (en_q),
    .mode_q   (mode_q)
  );

  baud_prescale #(.PRE_FAST(PRE_FAST), .PRE_SLOW(PRE_SLOW)) u_pre (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (en_q),
    .clk_en(clk_en),
    .mode  (mode_q),
    .step  (step)
  );

  baud_countdown #(.TC_W(TC_W)) u_cnt (
    .clk  (clk),
    .rst_n(rst_sync_n),
    .run  (en_q),
    .step (step),
    .tc   (tc_q),
    .term (term)
  );

  baud_toggle u_tog (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .run   (en_q),
    .term  (term),
    .out_q (baud_out),
    .tick_q(baud_tick)
  );
endmodule

// File: rtl/baud_rate_gen_chk.sv
module baud_rate_gen_chk (
  input logic clk,
  input logic rst_n,
  input logic en,
  input logic clk_en,
  input logic step,
  input logic term,
  input logic baud_out,
  input logic baud_tick
);
  // R6: a disabled generator drives a low output on the next cycle
  a_r6_off_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !baud_out);

  // R6: no tick while disabled
  a_r6_off_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !baud_tick);

  // R7: a tick always marks an output change
  a_r7_tick_change: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |-> (baud_out != $past(baud_out)));

  // R7: every rising output edge carries a tick
  a_r7_rise_tick: assert property (@(posedge clk) disable iff (!rst_n)
    (baud_out && !$past(baud_out)) |-> baud_tick);

  // R7: the tick lasts a single cycle
  a_r7_tick_single: assert property (@(posedge clk) disable iff (!rst_n)
    baud_tick |=> !baud_tick);

  // R8: the counter only advances on enabled input cycles
  a_r8_step_gated: assert property (@(posedge clk) disable iff (!rst_n)
    step |-> clk_en);

  // R7: a terminal count yields a tick one cycle later
  a_r7_term_tick: assert property (@(posedge clk) disable iff (!rst_n)
    term |=> baud_tick);
endmodule

bind baud_rate_gen baud_rate_gen_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_sync_n),
  .en       (en_q),
  .clk_en   (clk_en),
  .step     (step),
  .term     (term),
  .baud_out (baud_out),
  .baud_tick(baud_tick)
);

// File: tb/baud_rate_gen_tb.sv
module baud_rate_gen_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       clk_en = 1'b0;
  logic       tc_we = 1'b0;
  logic [7:0] tc_wdata = 8'd0;
  logic       ctl_we = 1'b0;
  logic [1:0] ctl_wdata = 2'd0;
  logic       baud_out;
  logic       baud_tick;

  int    n_checks = 0;
  int    n_fail = 0;
  int    cycles = 0;
  bit    done = 0;
  string cur_req = "R1";

  // behavioural reference model state
  int m_pre, m_cnt, m_tc;
  bit m_out, m_tick, m_en, m_mode;

  always #(CLK_PERIOD/2) clk = ~clk;

  baud_rate_gen u_dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .clk_en   (clk_en),
    .tc_we    (tc_we),
    .tc_wdata (tc_wdata),
    .ctl_we   (ctl_we),
    .ctl_wdata(ctl_wdata),
    .baud_out (baud_out),
    .baud_tick(baud_tick)
  );

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pre = 0; m_cnt = 0; m_tc = 0;
      m_out = 0; m_tick = 0; m_en = 0; m_mode = 0;
    end else begin
      m_tick = 0;
      if (!m_en) begin
        m_pre = 0;
        m_cnt = m_tc;
        m_out = 0;
      end else if (clk_en) begin
        if (m_pre >= (m_mode ? 31 : 1)) begin
          m_pre = 0;
          if (m_cnt == 1) begin
            m_cnt  = m_tc;
            m_out  = !m_out;
            m_tick = 1;
          end else begin
            m_cnt = (m_cnt + 255) % 256;
          end
        end else begin
          m_pre = m_pre + 1;
        end
      end
      if (tc_we) m_tc = tc_wdata;
      if (ctl_we) begin
        m_en   = ctl_wdata[0];
        m_mode = ctl_wdata[1];
      end
    end
  end

  task automatic check(string req, int act, int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d at cycle %0d", req, act, exp, cycles);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      check({cur_req, " out"}, baud_out, m_out);
      check({cur_req, " tick"}, baud_tick, m_tick);
    end
  end

  task automatic finish_run();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected below %0d cycles", cycles, WATCHDOG);
      finish_run();
    end
  end

  task automatic write_tc(int v);
    tc_we = 1; tc_wdata = 8'(v);
    @(negedge clk);
    tc_we = 0;
  endtask

  task automatic write_ctl(bit en, bit slow);
    ctl_we = 1; ctl_wdata = {slow, en};
    @(negedge clk);
    ctl_we = 0;
  endtask

  task automatic wait_tick();
    do @(negedge clk); while (!baud_tick);
  endtask

  task automatic gap(output int n);
    n = 0;
    do begin @(negedge clk); n++; end while (!baud_tick);
  endtask

  initial begin
    int g;
    repeat (3) @(negedge clk);
    check("R1 out in reset", baud_out, 0);
    check("R1 tick in reset", baud_tick, 0);
    rst_n = 1;
    repeat (6) @(negedge clk);
    check("R1 out after reset", baud_out, 0);
    check("R1 tick after reset", baud_tick, 0);

    // R2: fast mode, TC = 1 -> quarter rate
    cur_req = "R2";
    clk_en = 1;
    write_tc(1);
    write_ctl(1, 0);
    wait_tick();
    gap(g); check("R2 tc1 half period", g, 2);
    gap(g); check("R2 tc1 half period again", g, 2);

    // R6: disable holds low, re-enable restarts with full count
    cur_req = "R6";
    write_ctl(0, 0);
    write_tc(3);
    repeat (20) begin
      @(negedge clk);
      check("R6 disabled out", baud_out, 0);
      check("R6 disabled tick", baud_tick, 0);
    end
    ctl_we = 1; ctl_wdata = 2'b01;
    gap(g);
    ctl_we = 0;
    check("R6 first toggle after enable", g, 7);

    // R2: fast mode, TC = 5
    cur_req = "R2";
    write_ctl(0, 0);
    write_tc(5);
    write_ctl(1, 0);
    wait_tick();
    gap(g); check("R2 tc5 half period", g, 10);

    // R8: clk_en every other cycle doubles the interval
    cur_req = "R8";
    write_ctl(0, 0);
    write_tc(3);
    write_ctl(1, 0);
    fork
      begin
        repeat (200) begin
          clk_en = ~clk_en;
          @(negedge clk);
        end
      end
      begin
        wait_tick();
        gap(g); check("R8 gated half period", g, 12);
      end
    join
    clk_en = 1;

    // R5: constant change while running applies at next reload
    cur_req = "R5";
    write_ctl(0, 0);
    write_tc(4);
    write_ctl(1, 0);
    wait_tick();
    tc_we = 1; tc_wdata = 8'd2;
    gap(g);
    check("R5 old constant still in use", g, 8);
    gap(g); check("R5 new constant after reload", g, 4);
    tc_we = 0;
    @(negedge clk);
    wait_tick();
    gap(g); check("R5 new constant steady", g, 4);

    // R3: slow mode
    cur_req = "R3";
    write_ctl(0, 0);
    write_tc(2);
    write_ctl(1, 1);
    wait_tick();
    gap(g); check("R3 slow half period", g, 64);
    gap(g); check("R3 slow half period again", g, 64);

    // R4: constant 0 acts as 256
    cur_req = "R4";
    write_ctl(0, 0);
    write_tc(0);
    write_ctl(1, 0);
    wait_tick();
    gap(g); check("R4 zero constant half period", g, 512);

    // R7: tick width and edge pairing seen at the ports
    cur_req = "R7";
    write_ctl(0, 0);
    write_tc(1);
    write_ctl(1, 0);
    wait_tick();
    check("R7 tick with high out", baud_out, 1);
    @(negedge clk);
    check("R7 tick one cycle", baud_tick, 0);
    wait_tick();
    check("R7 tick with low out", baud_out, 0);

    finish_run();
  end
endmodule